// File: doc/BRIEF.md
# Upper-Region RAM/ROM Bank Controller

This block controls the upper 12K of a 16-bit CPU address space, from 0xD000 to 0xFFFF. A read in that region is served either by ROM or by bank-switched RAM. The block also decides whether RAM writes in the region are allowed. In the 0xD000–0xDFFF window it chooses which of two 4K RAM banks appears. The memory arrays are outside the block. The block supplies the read-source select, a per-access RAM write enable and the physical RAM address, which includes the main/auxiliary bank bit.

Software changes the mode by reading addresses in the switch page 0xC080–0xC08F. The low address bits of a switch read set three things: the read source, the 0xD000 bank and the write policy. A switch that allows writes only takes effect when the same switch address is read twice in a row with no other read in between. Two status addresses report the current bank and read source in bit 7.

Top module: `lc_bank_ctl`

## Requirements
- R1: After reset, reads in the region come from ROM (ram_rd_flag=0), bank 2 is selected (bank2_flag=1) and RAM writes are allowed (wr_en_flag=1).
- R2: A read of a switch address whose bits [1:0] are 00 selects RAM for reads. A read whose bits [1:0] are 10 selects ROM. Both write-protect the RAM from the next cycle.
- R3: A read of a switch address whose bit 0 is 1 selects RAM for reads when bit 1 is 1, and ROM when bit 1 is 0. It enables writes only if the previous read cycle, at any address, used the identical 16-bit address. Otherwise it write-protects. Any read in between breaks the pair.
- R4: A switch read with address bit 3 clear selects bank 2 (bank2_flag=1). With bit 3 set, it selects bank 1 (bank2_flag=0).
- R5: Address bit 2 is ignored in switch decoding, so 0xC084–0xC087 and 0xC08C–0xC08F act like the addresses with bit 2 cleared. Repeat detection still compares full addresses.
- R6: ram_we is 1 only in a cycle with wr_stb=1, an address at or above 0xD000 and writes allowed. A protected write leaves ram_we at 0.
- R7: ram_addr[15:0] equals cpu_addr minus 0x1000 for 0xD000–0xDFFF while bank 2 is selected. In every other case it equals cpu_addr. ram_addr[16] equals aux_zp.
- R8: rom_sel is 1 exactly in a cycle with rd_stb=1, an address at or above 0xD000 and ROM selected for reads.
- R9: A read of 0xC011 gives stat_hit=1 and stat_data bit 7 = bank2_flag. A read of 0xC012 gives stat_hit=1 and bit 7 = ram_rd_flag. Bits 6..0 are 0 in both cases.
- R10: A write cycle to the switch page changes no flag and does not disturb the two-read history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| rd_stb | input | 1 | Read cycle strobe |
| wr_stb | input | 1 | Write cycle strobe |
| aux_zp | input | 1 | Zero-page/upper bank flag: 1 selects auxiliary RAM |
| rom_sel | output | 1 | Current read is served by ROM |
| ram_we | output | 1 | RAM write enable for the current cycle |
| ram_addr | output | 17 | Physical RAM address, bit 16 is the bank bit |
| ram_rd_flag | output | 1 | RAM selected for region reads |
| bank2_flag | output | 1 | Bank 2 mapped at 0xD000 |
| wr_en_flag | output | 1 | RAM writes in the region allowed |
| stat_hit | output | 1 | Current read addresses a status location |
| stat_data | output | 8 | Status byte for the current read |

## Verification
Some properties are checked on every cycle. These are the flag updates after each kind of switch read, including the repeat rule (tracked by a separate previous-read register in the checker), the gating of ram_we and rom_sel, the zero low bits of the status byte and the stability of flags across write cycles. Other behaviours need the bench's ordered scenarios: the reset state, the physical address arithmetic for both banks and both RAM halves, the mirrored switch addresses, and the check that the read history survives a switch write.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef struct packed {
        logic ram_rd;
        logic bank2;
        logic wr_en;
    } lc_state_t;

    typedef enum logic [1:0] {
        MODE_RAM_PROT = 2'b00,
        MODE_ROM_ARM  = 2'b01,
        MODE_ROM_PROT = 2'b10,
        MODE_RAM_ARM  = 2'b11
    } lc_mode_e;

    localparam lc_state_t LC_RESET = '{ram_rd: 1'b0, bank2: 1'b1, wr_en: 1'b1};

    function automatic lc_state_t lc_next(input logic [3:0] low, input logic repeat_hit);
        lc_state_t s;
        lc_mode_e  m;
        m        = lc_mode_e'(low[1:0]);
        s.ram_rd = (m == MODE_RAM_PROT) || (m == MODE_RAM_ARM);
        s.bank2  = ~low[3];
        s.wr_en  = ((m == MODE_ROM_ARM) || (m == MODE_RAM_ARM)) && repeat_hit;
        return s;
    endfunction

endpackage

// File: rtl/lc_decode.sv
module lc_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SW_BASE  = 16'hC080,
    parameter logic [ADDR_W-1:0] RGN_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] ST_BANK  = 16'hC011,
    parameter logic [ADDR_W-1:0] ST_SRC   = 16'hC012
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sw_page,
    output logic              in_region,
    output logic              st_bank_hit,
    output logic              st_src_hit
);
    localparam int PAGE_LSB = 4;

    always_comb begin
        sw_page     = (addr[ADDR_W-1:PAGE_LSB] == SW_BASE[ADDR_W-1:PAGE_LSB]);
        in_region   = (addr >= RGN_BASE);
        st_bank_hit = (addr == ST_BANK);
        st_src_hit  = (addr == ST_SRC);
    end
endmodule

// File: rtl/lc_state.sv
module lc_state
    import lc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sw_page,
    output lc_state_t         state_q
);
    logic [ADDR_W-1:0] last_rd_q;
    logic              repeat_hit;

    assign repeat_hit = (last_rd_q == addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LC_RESET;
            last_rd_q <= '0;
        end else if (rd_stb) begin
            last_rd_q <= addr;
            if (sw_page)
                state_q <= lc_next(addr[3:0], repeat_hit);
        end
    end
endmodule

// File: rtl/lc_map.sv
module lc_map #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] RGN_BASE  = 16'hD000,
    parameter logic [ADDR_W-1:0] BANK_SPAN = 16'h1000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank2,
    input  logic              aux_zp,
    output logic [ADDR_W:0]   phys
);
    localparam logic [ADDR_W-1:0] DUP_END = RGN_BASE + BANK_SPAN;

    logic dup_win;

    always_comb begin
        dup_win = (addr >= RGN_BASE) && (addr < DUP_END);
        if (dup_win && bank2)
            phys = {aux_zp, addr - BANK_SPAN};
        else
            phys = {aux_zp, addr};
    end
endmodule

// File: rtl/lc_bank_ctl.sv
module lc_bank_ctl
    import lc_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] SW_BASE   = 16'hC080,
    parameter logic [ADDR_W-1:0] RGN_BASE  = 16'hD000,
    parameter logic [ADDR_W-1:0] BANK_SPAN = 16'h1000,
    parameter logic [ADDR_W-1:0] ST_BANK   = 16'hC011,
    parameter logic [ADDR_W-1:0] ST_SRC    = 16'hC012
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              aux_zp,
    output logic              rom_sel,
    output logic              ram_we,
    output logic [ADDR_W:0]   ram_addr,
    output logic              ram_rd_flag,
    output logic              bank2_flag,
    output logic              wr_en_flag,
    output logic              stat_hit,
    output logic [DATA_W-1:0] stat_data
);
    localparam int FLAG_BIT = DATA_W - 1;

    logic      sw_page, in_region, st_bank_hit, st_src_hit;
    lc_state_t st_q;

    lc_decode #(
        .ADDR_W(ADDR_W), .SW_BASE(SW_BASE), .RGN_BASE(RGN_BASE),
        .ST_BANK(ST_BANK), .ST_SRC(ST_SRC)
    ) u_dec (
        .addr(cpu_addr), .sw_page(sw_page), .in_region(in_region),
        .st_bank_hit(st_bank_hit), .st_src_hit(st_src_hit)
    );

    lc_state #(.ADDR_W(ADDR_W)) u_st (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .addr(cpu_addr),
        .sw_page(sw_page), .state_q(st_q)
    );

    lc_map #(.ADDR_W(ADDR_W), .RGN_BASE(RGN_BASE), .BANK_SPAN(BANK_SPAN)) u_map (
        .addr(cpu_addr), .bank2(st_q.bank2), .aux_zp(aux_zp), .phys(ram_addr)
    );

    always_comb begin
        ram_rd_flag = st_q.ram_rd;
        bank2_flag  = st_q.bank2;
        wr_en_flag  = st_q.wr_en;
        rom_sel     = rd_stb && in_region && !st_q.ram_rd;
        ram_we      = wr_stb && in_region && st_q.wr_en;
        stat_hit    = rd_stb && (st_bank_hit || st_src_hit);
        stat_data   = '0;
        if (rd_stb && st_bank_hit) stat_data[FLAG_BIT] = st_q.bank2;
        if (rd_stb && st_src_hit)  stat_data[FLAG_BIT] = st_q.ram_rd;
    end
endmodule

// File: rtl/lc_bank_ctl_chk.sv
module lc_bank_ctl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              rom_sel,
    input logic              ram_we,
    input logic              ram_rd_flag,
    input logic              bank2_flag,
    input logic              wr_en_flag,
    input logic              stat_hit,
    input logic [DATA_W-1:0] stat_data
);
    logic [ADDR_W-1:0] prev_rd;
    logic              sw_rd;

    always_ff @(posedge clk) begin
        if (rst) prev_rd <= '0;
        else if (rd_stb) prev_rd <= cpu_addr;
    end

    assign sw_rd = rd_stb && (cpu_addr[15:4] == 12'hC08);

    AST_EVEN_SWITCH_PROTECTS: assert property (@(posedge clk) disable iff (rst)
        sw_rd && !cpu_addr[0] |=> !wr_en_flag && (ram_rd_flag == !$past(cpu_addr[1]))); // R2
    AST_SINGLE_ODD_PROTECTS: assert property (@(posedge clk) disable iff (rst)
        sw_rd && cpu_addr[0] && (prev_rd != cpu_addr) |=> !wr_en_flag); // R3
    AST_DOUBLE_ODD_ARMS: assert property (@(posedge clk) disable iff (rst)
        sw_rd && cpu_addr[0] && (prev_rd == cpu_addr) |=> wr_en_flag && (ram_rd_flag == $past(cpu_addr[1]))); // R3
    AST_BANK_FROM_BIT3: assert property (@(posedge clk) disable iff (rst)
        sw_rd |=> bank2_flag == !$past(cpu_addr[3])); // R4
    AST_WE_GATED: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> wr_stb && wr_en_flag && (cpu_addr >= 16'hD000)); // R6
    AST_ROM_SEL_GATED: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> rd_stb && !ram_rd_flag && (cpu_addr >= 16'hD000)); // R8
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        stat_hit |-> stat_data[DATA_W-2:0] == '0); // R9
    AST_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        wr_stb && !rd_stb |=> $stable(ram_rd_flag) && $stable(bank2_flag) && $stable(wr_en_flag)); // R10
endmodule

bind lc_bank_ctl lc_bank_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rom_sel(rom_sel), .ram_we(ram_we), .ram_rd_flag(ram_rd_flag),
    .bank2_flag(bank2_flag), .wr_en_flag(wr_en_flag), .stat_hit(stat_hit),
    .stat_data(stat_data)
);

// File: tb/sim_lc_bank_ctl.sv
`timescale 1ns/1ps
module sim_lc_bank_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, aux_zp = 1'b0;
    logic        rom_sel, ram_we, ram_rd_flag, bank2_flag, wr_en_flag, stat_hit;
    logic [16:0] ram_addr;
    logic [7:0]  stat_data;

    logic        c_rom, c_we, c_hit;
    logic [16:0] c_addr;
    logic [7:0]  c_stat;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lc_bank_ctl u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .aux_zp(aux_zp), .rom_sel(rom_sel), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_rd_flag(ram_rd_flag), .bank2_flag(bank2_flag), .wr_en_flag(wr_en_flag),
        .stat_hit(stat_hit), .stat_data(stat_data)
    );

    // {address, ram_rd, bank2, wr_en} expected after each read, starting from reset
    localparam logic [18:0] VEC [14] = '{
        {16'hC080, 3'b110}, {16'hC081, 3'b010}, {16'hC081, 3'b011},
        {16'hC08B, 3'b100}, {16'hC08B, 3'b101}, {16'hC08B, 3'b101},
        {16'hC08A, 3'b000}, {16'hC089, 3'b000}, {16'hC089, 3'b001},
        {16'hC083, 3'b110}, {16'hC087, 3'b110}, {16'hC087, 3'b111},
        {16'hC082, 3'b010}, {16'hC088, 3'b100}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic rd, input logic wr);
        @(negedge clk);
        cpu_addr = a; rd_stb = rd; wr_stb = wr;
        #2;
        c_rom = rom_sel; c_we = ram_we; c_addr = ram_addr; c_hit = stat_hit; c_stat = stat_data;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic flags(input string tag, input logic [2:0] exp);
        check(tag, {29'd0, ram_rd_flag, bank2_flag, wr_en_flag}, {29'd0, exp});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        flags("R1 reset flags", 3'b011);
        access(16'hD010, 1'b0, 1'b1);
        check("R1 R6 write allowed after reset", {31'd0, c_we}, 32'd1);
        check("R7 bank2 low window", {15'd0, c_addr}, 32'h0C010);
        access(16'hD010, 1'b1, 1'b0);
        check("R8 rom after reset", {31'd0, c_rom}, 32'd1);

        for (int i = 0; i < 14; i++) begin
            access(VEC[i][18:3], 1'b1, 1'b0);
            flags($sformatf("R2 R3 R4 R5 vector %0d", i), VEC[i][2:0]);
        end
        // now RAM read, bank1, protected
        access(16'hD123, 1'b0, 1'b1);
        check("R6 protected write", {31'd0, c_we}, 32'd0);
        check("R7 bank1 direct", {15'd0, c_addr}, 32'h0D123);
        access(16'hD123, 1'b1, 1'b0);
        check("R8 ram read no rom_sel", {31'd0, c_rom}, 32'd0);

        // intervening read breaks the pair
        access(16'hC083, 1'b1, 1'b0);
        access(16'h1234, 1'b1, 1'b0);
        access(16'hC083, 1'b1, 1'b0);
        flags("R3 intervening read", 3'b110);
        access(16'hC083, 1'b1, 1'b0);
        flags("R3 pair after break", 3'b111);

        // region writes and mapping
        aux_zp = 1'b1;
        access(16'hE456, 1'b0, 1'b1);
        check("R6 enabled write", {31'd0, c_we}, 32'd1);
        check("R7 upper direct aux", {15'd0, c_addr}, 32'h1E456);
        access(16'h1000, 1'b0, 1'b1);
        check("R6 outside region", {31'd0, c_we}, 32'd0);
        aux_zp = 1'b0;

        // status reads: bank2=1, ram_rd=1
        access(16'hC011, 1'b1, 1'b0);
        check("R9 bank status", {23'd0, c_hit, c_stat}, 32'h180);
        access(16'hC012, 1'b1, 1'b0);
        check("R9 source status", {23'd0, c_hit, c_stat}, 32'h180);
        access(16'hC082, 1'b1, 1'b0);
        access(16'hC012, 1'b1, 1'b0);
        check("R9 source status rom", {23'd0, c_hit, c_stat}, 32'h100);

        // switch write changes nothing, history kept
        access(16'hC08B, 1'b1, 1'b0);
        flags("R10 setup", 3'b100);
        access(16'hC080, 1'b0, 1'b1);
        flags("R10 write no change", 3'b100);
        access(16'hC08B, 1'b1, 1'b0);
        flags("R10 history kept", 3'b101);

        // reset restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        flags("R1 second reset", 3'b011);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule